// File: doc/BRIEF.md
# Burst Address Sequencer with Dual Strobes

This block is the address and write-control front end of a synchronous burst SRAM. On a clock edge where either of two active-low address strobes is asserted and all three chip enables are in their active state, it captures the external address into an internal register. One strobe comes from the processor and one from the cache controller. Once an address is loaded, an active-low advance input steps the two low address bits through a four-beat burst. The order is either interleaved (start value XOR beat number) or linear (count up modulo four), chosen by a mode input. With advance inactive the address holds, which gives a wait cycle.

On the same edges the block turns a byte-write enable, two per-byte enables and a global write into registered write strobes for the lower lane (data bits 0 to 8) and the upper lane (data bits 9 to 17). Writes are accepted only on controller-strobe cycles and on advance cycles. A processor-strobe cycle always starts as a read. When both strobes arrive in the same cycle, the processor strobe wins. The memory array and the data drivers sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, addr_o is 0, sel_o is 0 and both write strobes are 0.
- R2: A rising edge with pstrobe_n=0, or with cstrobe_n=0, while the chip is on (ce_n=0, ce2=1, ce3_n=0) puts addr_i on addr_o and sets sel_o=1 in the following cycle.
- R3: A pstrobe_n load never writes: both write strobes are 0 after it, whatever bwe_n, lo_we_n, hi_we_n and gw_n are.
- R4: When pstrobe_n=0 and cstrobe_n=0 in the same cycle, the cycle is handled as a processor-strobe load (a read, no write strobes).
- R5: A strobe while the chip is off clears sel_o and both write strobes, and leaves addr_o unchanged.
- R6: With mode_i=0 (linear), each cycle with adv_n=0 and no strobe sets addr_o[1:0] to the previous value plus 1, modulo 4.
- R7: With mode_i=1 (interleaved), the n-th advance after a load sets addr_o[1:0] to the loaded low bits XOR (n mod 4). For example, 01 goes to 00, then 11, then 10.
- R8: A burst wraps to its start value after four beats, and advancing never changes addr_o[ADDR_W-1:2].
- R9: A cycle with no strobe and adv_n=1 holds addr_o, including the burst position, and gives no write strobes.
- R10: Lane decode on a controller-strobe or advance cycle while selected. wr_lo_o is 1 when gw_n=0, or when bwe_n=0 and lo_we_n=0. wr_hi_o is 1 when gw_n=0, or when bwe_n=0 and hi_we_n=0. So at least one strobe is 1 exactly when NOT((bwe_n OR (lo_we_n AND hi_we_n)) AND gw_n). With bwe_n=1 and gw_n=1 neither lane writes.
- R11: gw_n=0 writes both lanes whatever bwe_n, lo_we_n and hi_we_n are.
- R12: A strobe in the middle of a burst restarts the burst counter, so later advances step from the newly loaded low bits.
- R13: Write strobes are 0 whenever sel_o is 0, including on an advance cycle while deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | External address |
| pstrobe_n | input | 1 | Processor address strobe, active low, highest priority |
| cstrobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| mode_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| bwe_n | input | 1 | Byte-write enable, active low |
| lo_we_n | input | 1 | Lower lane write enable, active low |
| hi_we_n | input | 1 | Upper lane write enable, active low |
| gw_n | input | 1 | Global write, active low |
| addr_o | output | ADDR_W | Internal address |
| sel_o | output | 1 | Chip selected by the last strobe |
| wr_lo_o | output | 1 | Write strobe for data bits 0 to 8 |
| wr_hi_o | output | 1 | Write strobe for data bits 9 to 17 |

## Verification
The bench runs both burst orders from a start value that is not aligned, through all four beats and into the wrap. A design that carried into the upper address bits, or that used linear stepping in interleaved mode, would show a wrong address at the third or fifth beat. Wait cycles inserted mid-burst catch a counter that keeps moving while advance is inactive. Processor-strobe loads, and cycles with both strobes asserted, are driven with every write input active, which exposes a design that writes on a read or that gives the controller strobe priority. The lane decode is swept over byte enables with and without global write, and a reload in the middle of a burst shows whether the counter restarts from the new start value.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [2:0] {
        CMD_WAIT,
        CMD_ADV,
        CMD_PLOAD,
        CMD_CLOAD,
        CMD_DESEL
    } bseq_cmd_e;

endpackage

// File: rtl/bseq_lane_dec.sv
module bseq_lane_dec #(
    parameter int LANES = 2
) (
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_we_n,
    input  logic             gw_n,
    output logic [LANES-1:0] lane_wr
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_wr[g] = !gw_n || (!bwe_n && !lane_we_n[g]);
    end

endmodule

// File: rtl/bseq_burst_next.sv
module bseq_burst_next #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] beat,
    input  logic [CNT_W-1:0] cur,
    input  logic             interleave,
    output logic [CNT_W-1:0] nxt_beat,
    output logic [CNT_W-1:0] nxt_low
);

    always_comb begin
        nxt_beat = beat + 1'b1;
        if (interleave) begin
            nxt_low = start ^ nxt_beat;
        end else begin
            nxt_low = cur + 1'b1;
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              pstrobe_n,
    input  logic              cstrobe_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              mode_i,
    input  logic              bwe_n,
    input  logic              lo_we_n,
    input  logic              hi_we_n,
    input  logic              gw_n,
    output logic [ADDR_W-1:0] addr_o,
    output logic              sel_o,
    output logic              wr_lo_o,
    output logic              wr_hi_o
);

    localparam int CNT_W = 2;
    localparam int HI_W  = ADDR_W - CNT_W;
    localparam int LANES = 2;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [CNT_W-1:0] low;
        logic [CNT_W-1:0] start;
        logic [CNT_W-1:0] beat;
        logic             sel;
        logic [LANES-1:0] wr;
    } seq_st_t;

    seq_st_t    st_d, st_q;
    bseq_cmd_e  cmd;
    logic       chip_on;
    logic [LANES-1:0] lane_wr;
    logic [CNT_W-1:0] nxt_beat, nxt_low;

    bseq_lane_dec #(.LANES(LANES)) i_dec (
        .bwe_n     (bwe_n),
        .lane_we_n ({hi_we_n, lo_we_n}),
        .gw_n      (gw_n),
        .lane_wr   (lane_wr)
    );

    bseq_burst_next #(.CNT_W(CNT_W)) i_next (
        .start      (st_q.start),
        .beat       (st_q.beat),
        .cur        (st_q.low),
        .interleave (mode_i),
        .nxt_beat   (nxt_beat),
        .nxt_low    (nxt_low)
    );

    always_comb begin
        chip_on = !ce_n && ce2 && !ce3_n;
        if (!pstrobe_n) begin
            cmd = chip_on ? CMD_PLOAD : CMD_DESEL;
        end else if (!cstrobe_n) begin
            cmd = chip_on ? CMD_CLOAD : CMD_DESEL;
        end else if (!adv_n) begin
            cmd = CMD_ADV;
        end else begin
            cmd = CMD_WAIT;
        end

        st_d    = st_q;
        st_d.wr = '0;
        unique case (cmd)
            CMD_PLOAD, CMD_CLOAD: begin
                st_d.hi    = addr_i[ADDR_W-1:CNT_W];
                st_d.low   = addr_i[CNT_W-1:0];
                st_d.start = addr_i[CNT_W-1:0];
                st_d.beat  = '0;
                st_d.sel   = 1'b1;
                if (cmd == CMD_CLOAD) begin
                    st_d.wr = lane_wr;
                end
            end
            CMD_DESEL: begin
                st_d.sel = 1'b0;
            end
            CMD_ADV: begin
                st_d.low  = nxt_low;
                st_d.beat = nxt_beat;
                st_d.wr   = st_q.sel ? lane_wr : '0;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o  = {st_q.hi, st_q.low};
    assign sel_o   = st_q.sel;
    assign wr_lo_o = st_q.wr[0];
    assign wr_hi_o = st_q.wr[1];

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              pstrobe_n,
    input logic              cstrobe_n,
    input logic              adv_n,
    input logic              ce_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              gw_n,
    input logic [ADDR_W-1:0] addr_o,
    input logic              sel_o,
    input logic              wr_lo_o,
    input logic              wr_hi_o
);

    logic on;
    assign on = !ce_n && ce2 && !ce3_n;

    AST_PLOAD_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstrobe_n && on) |=> (addr_o == $past(addr_i) && sel_o && !wr_lo_o && !wr_hi_o)); // R3

    AST_OFF_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        ((!pstrobe_n || !cstrobe_n) && !on) |=> (!sel_o && $stable(addr_o))); // R5

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pstrobe_n && cstrobe_n && adv_n) |=> ($stable(addr_o) && !wr_lo_o && !wr_hi_o)); // R9

    AST_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (pstrobe_n && cstrobe_n && !adv_n) |=> (addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]))); // R8

    AST_GLOBAL_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (pstrobe_n && !cstrobe_n && on && !gw_n) |=> (wr_lo_o && wr_hi_o)); // R11

    AST_NOSEL_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_o |-> (!wr_lo_o && !wr_hi_o)); // R13

endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (addr_i),
    .pstrobe_n (pstrobe_n),
    .cstrobe_n (cstrobe_n),
    .adv_n     (adv_n),
    .ce_n      (ce_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .gw_n      (gw_n),
    .addr_o    (addr_o),
    .sel_o     (sel_o),
    .wr_lo_o   (wr_lo_o),
    .wr_hi_o   (wr_hi_o)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;

    localparam int ADDR_W = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic pstrobe_n = 1, cstrobe_n = 1, adv_n = 1;
    logic ce_n = 0, ce2 = 1, ce3_n = 0, mode_i = 0;
    logic bwe_n = 1, lo_we_n = 1, hi_we_n = 1, gw_n = 1;
    logic [ADDR_W-1:0] addr_o;
    logic sel_o, wr_lo_o, wr_hi_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) i_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .pstrobe_n(pstrobe_n), .cstrobe_n(cstrobe_n), .adv_n(adv_n),
        .ce_n(ce_n), .ce2(ce2), .ce3_n(ce3_n), .mode_i(mode_i),
        .bwe_n(bwe_n), .lo_we_n(lo_we_n), .hi_we_n(hi_we_n), .gw_n(gw_n),
        .addr_o(addr_o), .sel_o(sel_o), .wr_lo_o(wr_lo_o), .wr_hi_o(wr_hi_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        pstrobe_n = 1; cstrobe_n = 1; adv_n = 1;
        ce_n = 0; ce2 = 1; ce3_n = 0;
        bwe_n = 1; lo_we_n = 1; hi_we_n = 1; gw_n = 1;
    endtask

    task automatic cload(input logic [ADDR_W-1:0] a);
        idle(); addr_i = a; cstrobe_n = 0; tick(); idle();
    endtask

    task automatic adv_step();
        idle(); adv_n = 0; tick(); idle();
    endtask

    task automatic t_reset();
        chk("R1 addr", addr_o, 0);
        chk("R1 sel", sel_o, 0);
        chk("R1 wr", {wr_hi_o, wr_lo_o}, 0);
    endtask

    task automatic t_linear();
        logic [1:0] exp_low [5] = '{2'b01, 2'b10, 2'b11, 2'b00, 2'b01};
        mode_i = 0;
        cload(18'h2ABC5);
        chk("R2 addr", addr_o, 18'h2ABC5);
        chk("R2 sel", sel_o, 1);
        for (int i = 1; i < 5; i++) begin
            adv_step();
            chk("R6 linear low", addr_o[1:0], exp_low[i]);
            chk("R8 upper", addr_o[ADDR_W-1:2], 18'h2ABC5 >> 2);
        end
        chk("R8 wrap", addr_o, 18'h2ABC5);
    endtask

    task automatic t_interleave();
        logic [1:0] exp_low [5] = '{2'b01, 2'b00, 2'b11, 2'b10, 2'b01};
        mode_i = 1;
        cload(18'h00011);
        for (int i = 1; i < 5; i++) begin
            adv_step();
            chk("R7 interleave low", addr_o[1:0], exp_low[i]);
        end
        chk("R8 wrap upper", addr_o, 18'h00011);
        cload(18'h3FFFE);
        adv_step(); chk("R7 from 10 beat1", addr_o, 18'h3FFFF);
        adv_step(); chk("R7 from 10 beat2", addr_o, 18'h3FFFC);
        adv_step(); chk("R7 from 10 beat3", addr_o, 18'h3FFFD);
    endtask

    task automatic t_wait();
        mode_i = 1;
        cload(18'h01232);
        adv_step();
        chk("R7 beat1", addr_o, 18'h01233);
        idle(); bwe_n = 0; lo_we_n = 0; hi_we_n = 0; gw_n = 0; tick(); idle();
        chk("R9 hold addr", addr_o, 18'h01233);
        chk("R9 no wr", {wr_hi_o, wr_lo_o}, 0);
        tick();
        chk("R9 hold 2", addr_o, 18'h01233);
        adv_step();
        chk("R9 resume beat2", addr_o, 18'h01230);
    endtask

    task automatic t_pstrobe();
        idle(); addr_i = 18'h15557; pstrobe_n = 0;
        bwe_n = 0; lo_we_n = 0; hi_we_n = 0; gw_n = 0;
        tick(); idle();
        chk("R3 addr", addr_o, 18'h15557);
        chk("R3 no wr", {wr_hi_o, wr_lo_o}, 0);
        idle(); addr_i = 18'h0AAA8; pstrobe_n = 0; cstrobe_n = 0; gw_n = 0;
        tick(); idle();
        chk("R4 addr", addr_o, 18'h0AAA8);
        chk("R4 read", {wr_hi_o, wr_lo_o}, 0);
    endtask

    task automatic t_deselect();
        cload(18'h00100);
        idle(); addr_i = 18'h3F0F3; ce2 = 0; cstrobe_n = 0; gw_n = 0; tick(); idle();
        chk("R5 sel", sel_o, 0);
        chk("R5 addr", addr_o, 18'h00100);
        chk("R5 wr", {wr_hi_o, wr_lo_o}, 0);
        idle(); addr_i = 18'h3F0F3; ce3_n = 1; pstrobe_n = 0; tick(); idle();
        chk("R5 sel p", sel_o, 0);
        idle(); adv_n = 0; gw_n = 0; tick(); idle();
        chk("R13 adv deselected", {wr_hi_o, wr_lo_o}, 0);
    endtask

    task automatic t_bytes();
        logic [1:0] exp;
        for (int v = 0; v < 8; v++) begin
            idle(); addr_i = 18'h00040; cstrobe_n = 0;
            bwe_n = v[2]; hi_we_n = v[1]; lo_we_n = v[0];
            tick(); idle();
            exp = {(!v[2] && !v[1]), (!v[2] && !v[0])};
            chk("R10 cload lanes", {wr_hi_o, wr_lo_o}, exp);
        end
        idle(); adv_n = 0; bwe_n = 0; hi_we_n = 0; tick(); idle();
        chk("R10 adv upper only", {wr_hi_o, wr_lo_o}, 2'b10);
    endtask

    task automatic t_global();
        for (int v = 0; v < 8; v++) begin
            idle(); addr_i = 18'h00080; cstrobe_n = 0; gw_n = 0;
            bwe_n = v[2]; hi_we_n = v[1]; lo_we_n = v[0];
            tick(); idle();
            chk("R11 global", {wr_hi_o, wr_lo_o}, 2'b11);
        end
        idle(); adv_n = 0; gw_n = 0; bwe_n = 1; tick(); idle();
        chk("R11 global adv", {wr_hi_o, wr_lo_o}, 2'b11);
    endtask

    task automatic t_restart();
        mode_i = 0;
        cload(18'h00200);
        adv_step(); adv_step();
        chk("R6 mid", addr_o, 18'h00202);
        mode_i = 1;
        cload(18'h00303);
        chk("R12 reload", addr_o, 18'h00303);
        adv_step();
        chk("R12 restart beat1", addr_o, 18'h00302);
        adv_step();
        chk("R12 restart beat2", addr_o, 18'h00301);
    endtask

    initial begin
        idle();
        tick(); tick();
        t_reset();
        rst_n = 1;
        tick();
        t_reset();
        t_linear();
        t_interleave();
        t_wait();
        t_pstrobe();
        t_deselect();
        t_bytes();
        t_global();
        t_restart();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule